// File: doc/BRIEF.md
# Clos Middle-Stage Path Allocator

This block sets up connections through a three-stage unbuffered Clos circuit switch. The switch has a row of input-stage switches and a row of output-stage switches. Each edge switch carries a fixed number of external ports and one link to every middle-stage switch. For every edge switch the allocator keeps a bitmap of the middle switches that its live connections already occupy. A connection request names an input-stage switch and an output-stage switch. One cycle later the allocator answers with a middle switch that is idle in both bitmaps, or with an error flag when either edge switch is already at full load.

A release names the two edge switches and the middle switch of a live connection, and frees that middle switch in both bitmaps. The search takes the lowest free index over the OR of the two bitmaps. The middle stage must hold at least twice the port count less one switches. This count is checked when the design is elaborated. With that sizing, a request against edge switches that are below full load always finds a path. The blocked answer exists only to report a configuration that breaks this rule.

Top module: `clos_path_alloc`

## Requirements
- R1: After reset no response is pending (rsp_valid low), req_ready is high, and every bitmap is empty, so the first request to any pair of edge switches is granted middle switch 0.
- R2: A request taken on a clock edge (req_valid and req_ready both high) produces rsp_valid high for exactly the following cycle. Without an accepted request, rsp_valid is low.
- R3: A grant names the lowest-numbered middle switch that is free both at the requesting input switch and at the requesting output switch.
- R4: A grant marks the chosen middle switch busy at both edge switches, so later requests that touch either edge switch avoid it until it is released.
- R5: A release (rel_valid with rel_in, rel_out, rel_mid) frees that middle switch at both edge switches in the same cycle. Releasing a middle switch that is not in use changes nothing.
- R6: When the input switch or the output switch already carries PORTS connections, the answer is rsp_full with no grant, and neither bitmap changes.
- R7: A release has priority over a request. While rel_valid is high, req_ready is low and no request is taken.
- R8: NUM_MID must be at least 2*PORTS-1 at elaboration. With that sizing rsp_blocked never rises, including the worst case where the two edge switches together already occupy 2*PORTS-2 distinct middle switches.
- R9: While rsp_valid is high, exactly one of rsp_grant, rsp_full and rsp_blocked is high. Otherwise all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Connection request present |
| req_ready | output | 1 | Request can be taken this cycle (low while a release is presented) |
| req_in | input | IW | Index of the input-stage switch |
| req_out | input | IW | Index of the output-stage switch |
| rel_valid | input | 1 | Release present |
| rel_in | input | IW | Input-stage switch of the connection to free |
| rel_out | input | IW | Output-stage switch of the connection to free |
| rel_mid | input | MW | Middle switch of the connection to free |
| rsp_valid | output | 1 | Response to the request taken on the previous edge |
| rsp_grant | output | 1 | A path was found |
| rsp_full | output | 1 | An edge switch is at full load, so the request is refused |
| rsp_blocked | output | 1 | No common free middle switch (only possible if under-sized) |
| rsp_mid | output | MW | Chosen middle switch, valid with rsp_grant |

## Verification
Every input/output pair is first requested on an empty switch and then released. This separates a correct index decode from one that mixes up rows, since each pair must come back with middle switch 0. A directed pattern then builds the worst case, in which the two edge switches occupy disjoint busy sets, and the only path left is the highest middle switch. Further patterns fill an edge switch to full load and present a release on the same cycle as a request. A long deterministic mix of requests and releases is then checked against an arithmetic model of the bitmaps. This catches a wrong priority order, a missed clear and a missed set.

// File: rtl/clos_alloc_pkg.sv
package clos_alloc_pkg;

   typedef enum logic [1:0] {
      ANS_NONE    = 2'd0,
      ANS_GRANT   = 2'd1,
      ANS_FULL    = 2'd2,
      ANS_BLOCKED = 2'd3
   } ans_kind_t;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/busy_table.sv
module busy_table
   import clos_alloc_pkg::*;
#(
   parameter int ROWS     = 4,
   parameter int COLS     = 3,
   parameter int LOAD_MAX = 2,
   localparam int RW      = idx_w(ROWS),
   localparam int CW      = idx_w(COLS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       set_en,
   input  logic [RW-1:0]              set_row,
   input  logic [CW-1:0]              set_col,
   input  logic                       clr_en,
   input  logic [RW-1:0]              clr_row,
   input  logic [CW-1:0]              clr_col,
   input  logic [RW-1:0]              rd_row,
   output logic [COLS-1:0]            rd_bits,
   output logic                       rd_full,
   output logic [ROWS-1:0][COLS-1:0]  all_bits
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] row_q;
      logic            hit_clr;
      logic            hit_set;

      assign hit_clr = clr_en && (clr_row == RW'(r));
      assign hit_set = set_en && (set_row == RW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= '0;
         end else if (hit_clr) begin
            row_q[clr_col] <= 1'b0;
         end else if (hit_set) begin
            row_q[set_col] <= 1'b1;
         end
      end

      assign all_bits[r] = row_q;
   end

   assign rd_bits = all_bits[rd_row];
   assign rd_full = ($countones(rd_bits) >= LOAD_MAX);

endmodule

// File: rtl/lowest_free.sv
module lowest_free
   import clos_alloc_pkg::*;
#(
   parameter int N  = 3,
   localparam int MW = idx_w(N)
) (
   input  logic [N-1:0]  busy,
   output logic          found,
   output logic [MW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!busy[k]) begin
            found = 1'b1;
            idx   = MW'(k);
         end
      end
   end

endmodule

// File: rtl/clos_path_alloc.sv
module clos_path_alloc
   import clos_alloc_pkg::*;
#(
   parameter int NUM_EDGE = 4,
   parameter int PORTS    = 2,
   parameter int NUM_MID  = 3,
   localparam int IW      = idx_w(NUM_EDGE),
   localparam int MW      = idx_w(NUM_MID)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [IW-1:0] req_in,
   input  logic [IW-1:0] req_out,
   input  logic          rel_valid,
   input  logic [IW-1:0] rel_in,
   input  logic [IW-1:0] rel_out,
   input  logic [MW-1:0] rel_mid,
   output logic          rsp_valid,
   output logic          rsp_grant,
   output logic          rsp_full,
   output logic          rsp_blocked,
   output logic [MW-1:0] rsp_mid
);

   if (NUM_EDGE < 2) begin : g_bad_edge
      $error("clos_path_alloc: NUM_EDGE must be at least 2");
   end
   if (PORTS < 1) begin : g_bad_ports
      $error("clos_path_alloc: PORTS must be at least 1");
   end
   if (NUM_MID < 2 * PORTS - 1) begin : g_bad_mid
      $error("clos_path_alloc: NUM_MID below 2*PORTS-1 allows blocking");
   end

   logic                          take;
   logic [NUM_MID-1:0]            in_bits, out_bits, union_busy;
   logic                          in_full, out_full;
   logic                          pick_found;
   logic [MW-1:0]                 pick_idx;
   logic                          do_set;
   ans_kind_t                     ans_d, ans_q;
   logic [MW-1:0]                 mid_q;
   logic [IW-1:0]                 lat_in_q, lat_out_q;
   logic [NUM_EDGE-1:0][NUM_MID-1:0] in_map, out_map;

   assign req_ready = !rel_valid;
   assign take      = req_valid && req_ready;

   busy_table #(.ROWS(NUM_EDGE), .COLS(NUM_MID), .LOAD_MAX(PORTS)) u_in_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (do_set),
      .set_row  (req_in),
      .set_col  (pick_idx),
      .clr_en   (rel_valid),
      .clr_row  (rel_in),
      .clr_col  (rel_mid),
      .rd_row   (req_in),
      .rd_bits  (in_bits),
      .rd_full  (in_full),
      .all_bits (in_map)
   );

   busy_table #(.ROWS(NUM_EDGE), .COLS(NUM_MID), .LOAD_MAX(PORTS)) u_out_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (do_set),
      .set_row  (req_out),
      .set_col  (pick_idx),
      .clr_en   (rel_valid),
      .clr_row  (rel_out),
      .clr_col  (rel_mid),
      .rd_row   (req_out),
      .rd_bits  (out_bits),
      .rd_full  (out_full),
      .all_bits (out_map)
   );

   assign union_busy = in_bits | out_bits;

   lowest_free #(.N(NUM_MID)) u_pick (
      .busy  (union_busy),
      .found (pick_found),
      .idx   (pick_idx)
   );

   always_comb begin
      if (!take) begin
         ans_d = ANS_NONE;
      end else if (in_full || out_full) begin
         ans_d = ANS_FULL;
      end else if (pick_found) begin
         ans_d = ANS_GRANT;
      end else begin
         ans_d = ANS_BLOCKED;
      end
   end

   assign do_set = (ans_d == ANS_GRANT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ans_q     <= ANS_NONE;
         mid_q     <= '0;
         lat_in_q  <= '0;
         lat_out_q <= '0;
      end else begin
         ans_q <= ans_d;
         if (take) begin
            mid_q     <= pick_idx;
            lat_in_q  <= req_in;
            lat_out_q <= req_out;
         end
      end
   end

   assign rsp_valid   = (ans_q != ANS_NONE);
   assign rsp_grant   = (ans_q == ANS_GRANT);
   assign rsp_full    = (ans_q == ANS_FULL);
   assign rsp_blocked = (ans_q == ANS_BLOCKED);
   assign rsp_mid     = (ans_q == ANS_GRANT) ? mid_q : '0;

endmodule

// File: rtl/clos_alloc_chk.sv
module clos_alloc_chk #(
   parameter int NUM_EDGE = 4,
   parameter int NUM_MID  = 3,
   parameter int IW       = 2,
   parameter int MW       = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_valid,
   input logic                           req_ready,
   input logic                           rel_valid,
   input logic [IW-1:0]                  rel_in,
   input logic [IW-1:0]                  rel_out,
   input logic [MW-1:0]                  rel_mid,
   input logic                           rsp_valid,
   input logic                           rsp_grant,
   input logic                           rsp_full,
   input logic                           rsp_blocked,
   input logic [MW-1:0]                  rsp_mid,
   input logic [IW-1:0]                  lat_in_q,
   input logic [IW-1:0]                  lat_out_q,
   input logic [NUM_EDGE-1:0][NUM_MID-1:0] in_map,
   input logic [NUM_EDGE-1:0][NUM_MID-1:0] out_map
);

   // R2
   resp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R2
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   // R7
   release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> !req_ready);

   // R9
   one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_grant, rsp_full, rsp_blocked}));

   // R9
   quiet_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_grant || rsp_full || rsp_blocked));

   // R8
   never_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_blocked);

   // R4
   grant_marks_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> (in_map[lat_in_q][rsp_mid] && out_map[lat_out_q][rsp_mid]));

   // R6
   full_keeps_maps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_full |-> ($stable(in_map) && $stable(out_map)));

   // R5
   release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && (int'(rel_mid) < NUM_MID)) |=>
         (!in_map[$past(rel_in)][$past(rel_mid)] && !out_map[$past(rel_out)][$past(rel_mid)]));

endmodule

bind clos_path_alloc clos_alloc_chk #(
   .NUM_EDGE (NUM_EDGE),
   .NUM_MID  (NUM_MID),
   .IW       (IW),
   .MW       (MW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rel_valid   (rel_valid),
   .rel_in      (rel_in),
   .rel_out     (rel_out),
   .rel_mid     (rel_mid),
   .rsp_valid   (rsp_valid),
   .rsp_grant   (rsp_grant),
   .rsp_full    (rsp_full),
   .rsp_blocked (rsp_blocked),
   .rsp_mid     (rsp_mid),
   .lat_in_q    (lat_in_q),
   .lat_out_q   (lat_out_q),
   .in_map      (in_map),
   .out_map     (out_map)
);

// File: tb/sim_clos_path_alloc.sv
module sim_clos_path_alloc;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_EDGE   = 4;
   localparam int PORTS      = 2;
   localparam int NUM_MID    = 3;
   localparam int IW         = 2;
   localparam int MW         = 2;
   localparam int MAX_LIVE   = NUM_EDGE * PORTS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [IW-1:0] req_in = '0;
   logic [IW-1:0] req_out = '0;
   logic          rel_valid = 1'b0;
   logic [IW-1:0] rel_in = '0;
   logic [IW-1:0] rel_out = '0;
   logic [MW-1:0] rel_mid = '0;
   logic          rsp_valid, rsp_grant, rsp_full, rsp_blocked;
   logic [MW-1:0] rsp_mid;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [NUM_MID-1:0] m_in  [NUM_EDGE];
   logic [NUM_MID-1:0] m_out [NUM_EDGE];
   int live_i [MAX_LIVE];
   int live_j [MAX_LIVE];
   int live_k [MAX_LIVE];
   int live_n = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   clos_path_alloc #(.NUM_EDGE(NUM_EDGE), .PORTS(PORTS), .NUM_MID(NUM_MID)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_in(req_in), .req_out(req_out),
      .rel_valid(rel_valid), .rel_in(rel_in), .rel_out(rel_out), .rel_mid(rel_mid),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_full(rsp_full),
      .rsp_blocked(rsp_blocked), .rsp_mid(rsp_mid)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // expected answer: -1 means full, otherwise the middle switch index
   function automatic int expect_ans(input int i, input int j);
      if ($countones(m_in[i]) >= PORTS || $countones(m_out[j]) >= PORTS) return -1;
      for (int k = 0; k < NUM_MID; k++)
         if (!m_in[i][k] && !m_out[j][k]) return k;
      return -2;
   endfunction

   task automatic do_req(input int i, input int j, input string tag);
      int e;
      e = expect_ans(i, j);
      @(negedge clk);
      req_valid = 1'b1;
      req_in    = IW'(i);
      req_out   = IW'(j);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R2 response one cycle after take", int'(rsp_valid), 1);
      if (e >= 0) begin
         chk(rsp_grant && (int'(rsp_mid) == e), tag, rsp_grant ? int'(rsp_mid) : -1, e);
         m_in[i][e]  = 1'b1;
         m_out[j][e] = 1'b1;
         live_i[live_n] = i;
         live_j[live_n] = j;
         live_k[live_n] = e;
         live_n++;
      end else begin
         chk(rsp_full && !rsp_grant, {tag, " R6 full refusal"}, int'(rsp_full), 1);
      end
      chk(!rsp_blocked, "R8 never blocked", int'(rsp_blocked), 0);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 single-cycle response", int'(rsp_valid), 0);
   endtask

   task automatic do_rel(input int i, input int j, input int k);
      @(negedge clk);
      rel_valid = 1'b1;
      rel_in    = IW'(i);
      rel_out   = IW'(j);
      rel_mid   = MW'(k);
      @(negedge clk);
      rel_valid = 1'b0;
      m_in[i][k]  = 1'b0;
      m_out[j][k] = 1'b0;
   endtask

   task automatic drop_live(input int idx);
      do_rel(live_i[idx], live_j[idx], live_k[idx]);
      live_i[idx] = live_i[live_n - 1];
      live_j[idx] = live_j[live_n - 1];
      live_k[idx] = live_k[live_n - 1];
      live_n--;
   endtask

   task automatic drop_all();
      while (live_n > 0) drop_live(live_n - 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      for (int e = 0; e < NUM_EDGE; e++) begin
         m_in[e]  = '0;
         m_out[e] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

      // R1 R3 every pair on an empty switch gets middle 0
      for (int i = 0; i < NUM_EDGE; i++)
         for (int j = 0; j < NUM_EDGE; j++) begin
            do_req(i, j, "R1 R3 empty-switch grant");
            drop_all();
         end

      // R8 worst case: union of two disjoint busy sets, only top index free
      do_req(0, 0, "R3 first");
      do_req(1, 1, "R3 second");
      do_req(1, 2, "R4 avoids busy at input");
      do_req(0, 2, "R8 worst-case union picks last middle");
      chk(live_k[3] == NUM_MID - 1, "R8 last middle used", live_k[3], NUM_MID - 1);
      // R6 edge 0 and 1 now at full load
      do_req(0, 3, "R6 input full");
      do_req(3, 2, "R6 output full");
      // R4 after refusal the maps are unchanged: edge 3 pair still gets 0
      do_req(3, 3, "R4 R6 maps untouched by refusal");
      drop_all();

      // R5 release of an unused middle has no effect
      do_req(3, 3, "R5 setup");
      do_rel(3, 3, 1);
      do_req(3, 3, "R5 unused release keeps middle 0 busy");
      do_req(3, 3, "R5 R6 load count intact");
      drop_all();

      // R7 release and request on the same cycle
      do_req(2, 2, "R7 setup");
      @(negedge clk);
      rel_valid = 1'b1;
      rel_in = 2'd2; rel_out = 2'd2; rel_mid = 2'd0;
      req_valid = 1'b1;
      req_in = 2'd1; req_out = 2'd1;
      #1;
      chk(req_ready == 1'b0, "R7 ready low during release", int'(req_ready), 0);
      @(negedge clk);
      rel_valid = 1'b0;
      req_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R7 request not taken", int'(rsp_valid), 0);
      m_in[2][0] = 1'b0;
      m_out[2][0] = 1'b0;
      live_n = 0;
      // R5 release took effect: pair (2,2) gets 0 again; pair (1,1) was not booked
      do_req(2, 2, "R5 released middle reusable");
      do_req(1, 1, "R7 dropped request left no booking");
      drop_all();

      // R3 R4 R5 long deterministic mix against the model
      for (int s = 0; s < 600; s++) begin
         if ((s % 4 == 3) && live_n > 0) begin
            drop_live((s * 7) % live_n);
         end else begin
            do_req((s * 3 + s / 5) % NUM_EDGE, (s * 5 + s / 7) % NUM_EDGE, "R3 R4 mixed traffic");
         end
      end
      drop_all();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule